// File: doc/BRIEF.md
# Bank-typed packed SIMD add/subtract unit

This unit adds or subtracts two 32-bit integer register values as packed lanes. No opcode field gives the lane type. The unit takes it from the register indices. The destination index picks one of five banks: signed bytes, unsigned bytes, signed halfwords, unsigned halfwords, or a single signed word. Both sources must sit in that same bank, or be the zero register. A one-cycle operation can wrap, saturate or halve. The result is registered together with per-byte write enables, so a register file next to the unit can commit it directly.

A two-bit mode field on each instruction does two jobs. It can apply a per-lane predicate taken from the value of register 1, as is or inverted. It can also force saturation for that one instruction instead of following the global saturate enable. A sticky overflow flag records any saturation in a lane that was written. An illegal-operand pulse reports a bank mismatch or a reserved register, and in that case nothing is written.

Top module: `simd_bank_adder`

## Requirements
- R1: The destination index sets the lane type. Registers 2..7 hold signed 8-bit lanes. Registers 8..15 hold unsigned 8-bit lanes. Registers 16..23 hold signed 16-bit lanes. Registers 24..29 hold unsigned 16-bit lanes. Registers 30..31 hold one signed 32-bit lane. Lane k occupies bits [k*W +: W].
- R2: A source index of 0 reads as zero whatever its value input carries, and it is accepted with a destination in any bank.
- R3: The operation is illegal when the destination is 0 or 1, when a source is 1, or when a non-zero source lies in a bank other than the destination's. An illegal operation raises illegal_o for one cycle and keeps wr_en_o and lane_we_o at zero. It leaves result_o and overflow_o unchanged.
- R4: op_i bit 0 selects subtract (1) or add (0), and op_i bit 1 selects halving. Without saturation or halving, each lane result is the sum or difference modulo 2^W.
- R5: Saturation applies when mode_i is 01, or when sat_en_i is 1 under any other mode. Signed lanes then clamp to [-2^(W-1), 2^(W-1)-1] and unsigned lanes to [0, 2^W-1].
- R6: A halving lane returns floor((a±b)/2) computed exactly, taken modulo 2^W. It never saturates and never sets overflow.
- R7: Mode 10 enables a lane when bit k*W of pred_i is 1. Mode 11 enables it when that bit is 0. Modes 00 and 01 enable every lane. A disabled lane passes rd_old_i through to result_o and drives its byte enables low.
- R8: overflow_o becomes 1 after any legal operation in which an enabled lane clamps. It stays 1 until reset.
- R9: Outputs are registered and appear on the clock edge that samples valid_i. wr_en_o and illegal_o are single-cycle pulses. With valid_i low the unit writes nothing and result_o holds.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | bit0 subtract, bit1 halving |
| mode_i | input | 2 | 00 global sat, 01 forced sat, 10 predicate, 11 inverted predicate |
| sat_en_i | input | 1 | Global saturate enable |
| rd_idx_i | input | 5 | Destination register index |
| rs1_idx_i | input | 5 | First source register index |
| rs2_idx_i | input | 5 | Second source register index |
| rs1_val_i | input | 32 | First source value |
| rs2_val_i | input | 32 | Second source value |
| rd_old_i | input | 32 | Current destination value |
| pred_i | input | 32 | Value of register 1 |
| result_o | output | 32 | Merged result |
| lane_we_o | output | 4 | Byte write enables |
| wr_en_o | output | 1 | Register write strobe |
| illegal_o | output | 1 | Illegal-operand pulse |
| overflow_o | output | 1 | Sticky saturation flag |

## Verification
The bench drives lanes that sit exactly at the clamp points, with signed and unsigned types at each width. A unit that took signedness from the wrong bank clamps to the wrong limit, and one that lost the carry bit gets the halved results wrong. Halving is exercised on inputs that would saturate, and predication is exercised with the clamping lane switched off. A design that saturated halved sums, or counted a masked lane, would raise overflow too early. Mixed-bank, reserved-register and zero-source operands check that illegal operations never strobe a write, and that register 0 reads as zero.

// File: rtl/simd_bank_pkg.sv
`timescale 1ns/1ps
package simd_bank_pkg;
  localparam int unsigned IDX_W = 5;

  localparam logic [IDX_W-1:0] U8_LO  = 5'd8;
  localparam logic [IDX_W-1:0] S16_LO = 5'd16;
  localparam logic [IDX_W-1:0] U16_LO = 5'd24;
  localparam logic [IDX_W-1:0] S32_LO = 5'd30;

  localparam logic [1:0] MODE_FORCE = 2'b01;

  typedef enum logic [2:0] {
    BK_S8, BK_U8, BK_S16, BK_U16, BK_S32, BK_ZERO, BK_PRED
  } bank_e;

  typedef enum logic [1:0] {LW_8, LW_16, LW_32} lane_w_e;

  function automatic bank_e bank_of(logic [IDX_W-1:0] idx);
    if (idx == '0)              return BK_ZERO;
    else if (idx == 5'd1)       return BK_PRED;
    else if (idx < U8_LO)       return BK_S8;
    else if (idx < S16_LO)      return BK_U8;
    else if (idx < U16_LO)      return BK_S16;
    else if (idx < S32_LO)      return BK_U16;
    else                        return BK_S32;
  endfunction
endpackage

// File: rtl/simd_bank_decode.sv
`timescale 1ns/1ps
module simd_bank_decode
  import simd_bank_pkg::*;
(
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] rs1_idx_i,
  input  logic [IDX_W-1:0] rs2_idx_i,
  output logic             legal_o,
  output logic             zero_a_o,
  output logic             zero_b_o,
  output lane_w_e          width_o,
  output logic             signed_o
);
  bank_e bd, b1, b2;

  assign bd = bank_of(rd_idx_i);
  assign b1 = bank_of(rs1_idx_i);
  assign b2 = bank_of(rs2_idx_i);

  assign zero_a_o = (b1 == BK_ZERO);
  assign zero_b_o = (b2 == BK_ZERO);

  always_comb begin
    legal_o = (bd != BK_ZERO) && (bd != BK_PRED)
           && (zero_a_o || b1 == bd)
           && (zero_b_o || b2 == bd);
    unique case (bd)
      BK_S8, BK_U8:   width_o = LW_8;
      BK_S16, BK_U16: width_o = LW_16;
      default:        width_o = LW_32;
    endcase
    signed_o = (bd == BK_S8) || (bd == BK_S16) || (bd == BK_S32);
  end
endmodule

// File: rtl/simd_lane_alu.sv
`timescale 1ns/1ps
module simd_lane_alu #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         halve_i,
  input  logic         sgn_i,
  input  logic         sat_i,
  output logic [W-1:0] res_o,
  output logic         clamp_o
);
  localparam int unsigned EW = W + 2;

  logic signed [EW-1:0] ea, eb, s;
  logic signed [EW-1:0] smax, smin, umax, zero;
  logic hi, lo;

  assign ea = sgn_i ? {{2{a_i[W-1]}}, a_i} : {2'b00, a_i};
  assign eb = sgn_i ? {{2{b_i[W-1]}}, b_i} : {2'b00, b_i};
  assign s  = sub_i ? (ea - eb) : (ea + eb);

  assign smax = {{3{1'b0}}, {(W-1){1'b1}}};
  assign smin = {{3{1'b1}}, {(W-1){1'b0}}};
  assign umax = {2'b00, {W{1'b1}}};
  assign zero = '0;

  assign hi = sgn_i ? (s > smax) : (s > umax);
  assign lo = sgn_i ? (s < smin) : (s < zero);

  always_comb begin
    clamp_o = 1'b0;
    if (halve_i) begin
      res_o = s[W:1];                 // exact floor divide by two
    end else if (sat_i && hi) begin
      res_o   = sgn_i ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
      clamp_o = 1'b1;
    end else if (sat_i && lo) begin
      res_o   = sgn_i ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};
      clamp_o = 1'b1;
    end else begin
      res_o = s[W-1:0];
    end
  end
endmodule

// File: rtl/simd_bank_adder.sv
`timescale 1ns/1ps
module simd_bank_adder
  import simd_bank_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic              sat_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  rs1_idx_i,
  input  logic [IDX_W-1:0]  rs2_idx_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [XLEN-1:0]   rs2_val_i,
  input  logic [XLEN-1:0]   rd_old_i,
  input  logic [XLEN-1:0]   pred_i,
  output logic [XLEN-1:0]   result_o,
  output logic [XLEN/8-1:0] lane_we_o,
  output logic              wr_en_o,
  output logic              illegal_o,
  output logic              overflow_o
);
  localparam int unsigned NB = XLEN / 8;
  localparam int unsigned NH = XLEN / 16;

  logic          legal, zero_a, zero_b, sgn, sat, sub, halve;
  lane_w_e       width;
  logic [XLEN-1:0] a_v, b_v, pmask;
  logic [XLEN-1:0] res8, res16, res32, raw, merged;
  logic [NB-1:0] clamp8, en8, be;
  logic [NH-1:0] clamp16, en16;
  logic          clamp32, en32, hit;

  simd_bank_decode u_dec (
    .rd_idx_i (rd_idx_i),
    .rs1_idx_i(rs1_idx_i),
    .rs2_idx_i(rs2_idx_i),
    .legal_o  (legal),
    .zero_a_o (zero_a),
    .zero_b_o (zero_b),
    .width_o  (width),
    .signed_o (sgn)
  );

  assign a_v   = zero_a ? '0 : rs1_val_i;
  assign b_v   = zero_b ? '0 : rs2_val_i;
  assign sub   = op_i[0];
  assign halve = op_i[1];
  assign sat   = (mode_i == MODE_FORCE) || sat_en_i;
  assign pmask = mode_i[1] ? (mode_i[0] ? ~pred_i : pred_i) : '1;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane_alu #(.W(8)) u_alu (
      .a_i(a_v[8*i +: 8]), .b_i(b_v[8*i +: 8]),
      .sub_i(sub), .halve_i(halve), .sgn_i(sgn), .sat_i(sat),
      .res_o(res8[8*i +: 8]), .clamp_o(clamp8[i])
    );
    assign en8[i] = pmask[8*i];
  end

  for (genvar j = 0; j < NH; j++) begin : g_half
    simd_lane_alu #(.W(16)) u_alu (
      .a_i(a_v[16*j +: 16]), .b_i(b_v[16*j +: 16]),
      .sub_i(sub), .halve_i(halve), .sgn_i(sgn), .sat_i(sat),
      .res_o(res16[16*j +: 16]), .clamp_o(clamp16[j])
    );
    assign en16[j] = pmask[16*j];
  end

  simd_lane_alu #(.W(XLEN)) u_word (
    .a_i(a_v), .b_i(b_v),
    .sub_i(sub), .halve_i(halve), .sgn_i(sgn), .sat_i(sat),
    .res_o(res32), .clamp_o(clamp32)
  );
  assign en32 = pmask[0];

  logic unused_pmask;
  assign unused_pmask = ^pmask;

  always_comb begin
    be  = '0;
    raw = res32;
    hit = 1'b0;
    unique case (width)
      LW_8: begin
        be  = en8;
        raw = res8;
        hit = |(clamp8 & en8);
      end
      LW_16: begin
        for (int j = 0; j < NH; j++) be[2*j +: 2] = {2{en16[j]}};
        raw = res16;
        hit = |(clamp16 & en16);
      end
      default: begin
        be  = {NB{en32}};
        raw = res32;
        hit = clamp32 & en32;
      end
    endcase
    for (int i = 0; i < NB; i++)
      merged[8*i +: 8] = be[i] ? raw[8*i +: 8] : rd_old_i[8*i +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= '0;
      lane_we_o  <= '0;
      wr_en_o    <= 1'b0;
      illegal_o  <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      wr_en_o   <= valid_i && legal;
      illegal_o <= valid_i && !legal;
      lane_we_o <= (valid_i && legal) ? be : '0;
      if (valid_i && legal) begin
        result_o <= merged;
        if (hit) overflow_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/simd_bank_adder_chk.sv
`timescale 1ns/1ps
module simd_bank_adder_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [1:0]        mode_i,
  input logic              sat_en_i,
  input logic [XLEN/8-1:0] lane_we_o,
  input logic              wr_en_o,
  input logic              illegal_o,
  input logic              overflow_o
);
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && lane_we_o == '0)); // R3

  AST_WE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_we_o != '0) |-> wr_en_o); // R7

  AST_UNPRED_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i[1]) |=> (!wr_en_o || lane_we_o == '1)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr_en_o && !illegal_o)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R8

  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(valid_i && !op_i[1] && (mode_i == 2'b01 || sat_en_i))); // R5

  AST_OVF_HALVE_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[1] && !overflow_o) |=> !overflow_o); // R6
endmodule

bind simd_bank_adder simd_bank_adder_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/simd_bank_adder_tb_top.sv
`timescale 1ns/1ps
module simd_bank_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = '0, mode = '0;
  logic        sat_en = 1'b0;
  logic [4:0]  rd = '0, rs1 = '0, rs2 = '0;
  logic [31:0] a = '0, b = '0, old = '0, pred = '0;
  logic [31:0] result;
  logic [3:0]  lane_we;
  logic        wr_en, illegal, overflow;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_res = '0;
  logic        exp_ovf = 1'b0;

  always #2.5 clk = ~clk;

  simd_bank_adder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .mode_i(mode),
    .sat_en_i(sat_en), .rd_idx_i(rd), .rs1_idx_i(rs1), .rs2_idx_i(rs2),
    .rs1_val_i(a), .rs2_val_i(b), .rd_old_i(old), .pred_i(pred),
    .result_o(result), .lane_we_o(lane_we), .wr_en_o(wr_en),
    .illegal_o(illegal), .overflow_o(overflow)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // 0 S8, 1 U8, 2 S16, 3 U16, 4 S32, 5 zero, 6 predicate
  function automatic int bank(input int idx);
    if (idx == 0) return 5;
    if (idx == 1) return 6;
    if (idx <= 7) return 0;
    if (idx <= 15) return 1;
    if (idx <= 23) return 2;
    if (idx <= 29) return 3;
    return 4;
  endfunction

  function automatic int pick_reg(input int k);
    case (k)
      0: return 2 + int'($urandom % 6);
      1: return 8 + int'($urandom % 8);
      2: return 16 + int'($urandom % 8);
      3: return 24 + int'($urandom % 6);
      default: return 30 + int'($urandom % 2);
    endcase
  endfunction

  function automatic longint lane_fn(input longint x, input longint y, input int w, input bit sgn,
                                     input bit sub, input bit halve, input bit sat, output bit clamp);
    longint m = (longint'(1) << w) - 1;
    longint ex = x, ey = y, s, hi, lo;
    clamp = 0;
    if (sgn && ((x >> (w - 1)) & 1) != 0) ex = x - (longint'(1) << w);
    if (sgn && ((y >> (w - 1)) & 1) != 0) ey = y - (longint'(1) << w);
    s = sub ? ex - ey : ex + ey;
    if (halve) return (s >>> 1) & m;
    hi = sgn ? (longint'(1) << (w - 1)) - 1 : m;
    lo = sgn ? -(longint'(1) << (w - 1)) : 0;
    if (sat && s > hi) begin clamp = 1; return hi & m; end
    if (sat && s < lo) begin clamp = 1; return lo & m; end
    return s & m;
  endfunction

  task automatic run_op(input string tag, input logic [1:0] o, input logic [1:0] md, input logic se,
                        input int d, input int s1, input int s2,
                        input logic [31:0] va, input logic [31:0] vb,
                        input logic [31:0] vo, input logic [31:0] vp);
    int bd = bank(d), b1 = bank(s1), b2 = bank(s2);
    bit legal = (bd <= 4) && (b1 == bd || b1 == 5) && (b2 == bd || b2 == 5);
    int w = (bd <= 1) ? 8 : (bd <= 3) ? 16 : 32;
    bit sgn = (bd == 0) || (bd == 2) || (bd == 4);
    bit satv = (md == 2'b01) || se;
    longint av = (s1 == 0) ? 0 : longint'(va);
    longint bv = (s2 == 0) ? 0 : longint'(vb);
    longint r = 0, m = (longint'(1) << w) - 1;
    logic [3:0] ebe = '0;
    bit hit = 0;
    for (int l = 0; l < 32 / w; l++) begin
      bit en = md[1] ? (vp[l * w] ^ md[0]) : 1'b1;
      bit c;
      longint lr = lane_fn((av >> (l * w)) & m, (bv >> (l * w)) & m, w, sgn, o[0], o[1], satv, c);
      if (en) begin
        r |= lr << (l * w);
        for (int k = 0; k < w / 8; k++) ebe[l * (w / 8) + k] = 1'b1;
        if (c) hit = 1;
      end else begin
        r |= ((longint'(vo) >> (l * w)) & m) << (l * w);
      end
    end
    if (legal) begin
      exp_res = r[31:0];
      if (hit) exp_ovf = 1'b1;
    end
    @(negedge clk);
    valid = 1'b1; op = o; mode = md; sat_en = se;
    rd = 5'(d); rs1 = 5'(s1); rs2 = 5'(s2); a = va; b = vb; old = vo; pred = vp;
    @(posedge clk);
    #1;
    check(tag, "result", result, exp_res);
    check(tag, "lane_we", {28'b0, lane_we}, legal ? {28'b0, ebe} : 32'b0);
    check(tag, "wr_en", {31'b0, wr_en}, {31'b0, legal});
    check(tag, "illegal", {31'b0, illegal}, {31'b0, !legal});
    check(tag, "overflow", {31'b0, overflow}, {31'b0, exp_ovf});
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic check_reset_state(input string tag);
    check(tag, "reset result", result, 32'h0);
    check(tag, "reset lane_we", {28'b0, lane_we}, 32'h0);
    check(tag, "reset wr_en", {31'b0, wr_en}, 32'h0);
    check(tag, "reset illegal", {31'b0, illegal}, 32'h0);
    check(tag, "reset overflow", {31'b0, overflow}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(posedge clk);
    #1;
    check_reset_state("R10");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 signed bytes, wrap with saturation off
    run_op("R1", 2'b00, 2'b00, 1'b0, 3, 4, 5, 32'h7f01_80ff, 32'h0101_ff01, 32'h0, 32'h0);
    // R4 unsigned halfword subtract wraps
    run_op("R4", 2'b01, 2'b00, 1'b0, 24, 25, 26, 32'h0005_0000, 32'h0007_0001, 32'h0, 32'h0);
    // R6 halving on saturating inputs: exact, no overflow
    run_op("R6", 2'b10, 2'b00, 1'b1, 17, 18, 19, 32'h7fff_8000, 32'h7fff_8000, 32'h0, 32'h0);
    run_op("R6", 2'b11, 2'b01, 1'b0, 9, 10, 11, 32'h0000_0003, 32'h0101_0101, 32'h0, 32'h0);
    run_op("R6", 2'b10, 2'b00, 1'b0, 20, 21, 22, 32'hfffd_0003, 32'h0000_0000, 32'h0, 32'h0);
    // R7 predicate: clamping lanes disabled, old value kept
    run_op("R7", 2'b00, 2'b10, 1'b1, 2, 3, 4, 32'h7f7f_0101, 32'h0101_0101, 32'hdead_beef, 32'h0000_0101);
    // R8 inverted predicate enables the clamping lanes, overflow sets
    run_op("R8", 2'b00, 2'b11, 1'b1, 2, 3, 4, 32'h7f7f_0101, 32'h0101_0101, 32'hdead_beef, 32'h0000_0101);
    // R5 forced saturation, unsigned byte underflow and signed word overflow
    run_op("R5", 2'b01, 2'b01, 1'b0, 12, 13, 14, 32'h0000_0510, 32'h0101_0101, 32'h0, 32'h0);
    run_op("R5", 2'b00, 2'b01, 1'b0, 30, 31, 30, 32'h7fff_ffff, 32'h0000_0001, 32'h0, 32'h0);
    run_op("R5", 2'b01, 2'b00, 1'b1, 16, 17, 18, 32'h8000_7fff, 32'h0001_ffff, 32'h0, 32'h0);
    run_op("R5", 2'b00, 2'b00, 1'b1, 27, 28, 29, 32'hffff_0001, 32'h0002_0001, 32'h0, 32'h0);
    // R2 zero register as source, value input ignored
    run_op("R2", 2'b01, 2'b00, 1'b0, 17, 0, 18, 32'h1234_5678, 32'h0001_0002, 32'h0, 32'h0);
    run_op("R2", 2'b00, 2'b00, 1'b0, 8, 9, 0, 32'h0102_0304, 32'hffff_ffff, 32'h0, 32'h0);
    // R3 illegal operands
    run_op("R3", 2'b00, 2'b00, 1'b0, 3, 9, 4, 32'h1, 32'h1, 32'h0, 32'h0);
    run_op("R3", 2'b00, 2'b00, 1'b0, 1, 2, 3, 32'h1, 32'h1, 32'h0, 32'h0);
    run_op("R3", 2'b00, 2'b00, 1'b0, 0, 2, 3, 32'h1, 32'h1, 32'h0, 32'h0);
    run_op("R3", 2'b00, 2'b00, 1'b0, 20, 21, 1, 32'h1, 32'h1, 32'h0, 32'h0);
    // R9 idle cycle: no write, result holds
    @(negedge clk);
    a = 32'hffff_ffff; rd = 5'd3; rs1 = 5'd3; rs2 = 5'd3;
    @(posedge clk);
    #1;
    check("R9", "idle wr_en", {31'b0, wr_en}, 32'h0);
    check("R9", "idle result", result, exp_res);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int k = int'($urandom % 5);
      int d = pick_reg(k);
      int s1 = ($urandom % 10 == 0) ? 0 : pick_reg(k);
      int s2 = ($urandom % 10 == 0) ? 0 : pick_reg(k);
      if ($urandom % 20 == 0) s2 = pick_reg(int'($urandom % 5));
      run_op("R1", 2'($urandom), 2'($urandom), 1'($urandom), d, s1, s2,
             $urandom, $urandom, $urandom, $urandom);
    end

    // R8 overflow clears only through reset
    @(negedge clk);
    rst_n = 1'b0;
    exp_ovf = 1'b0;
    exp_res = '0;
    @(posedge clk);
    #1;
    check_reset_state("R8");
    @(negedge clk);
    rst_n = 1'b1;
    run_op("R10", 2'b00, 2'b00, 1'b0, 24, 25, 26, 32'h0001_0001, 32'h0001_0001, 32'h0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule